// File: doc/BRIEF.md
# Bidirectional Row Scan Shifter

This block is the logic core of a display row (gate-line) driver. A single start pulse is captured at one end of a chain of row stages and moves one row further on every rising edge of the shift clock. The active row output tells the output stage which gate line to open. A direction input decides which end receives the pulse. The opposite end returns a cascade pulse, so that several devices can be chained in series.

Two shared pins carry the start and cascade pulses. Each one is an input at the receiving end and an output at the emitting end, and the direction input sets which is which. A length-select input can remove a contiguous group of middle rows from the chain, which shortens the scan. Two asynchronous overrides act on the row outputs only: a blanking input and an active-low all-rows-on input. The stored pulse position is not affected by either one. The parameters set the row count and the position and size of the removable group. The defaults give 263 rows with rows 129 to 135 removable, so the short chain is 256 rows long.

Top module: `row_scan_shifter`

## Requirements
- R1: While `rst_n` is low, every row stage and the cascade flop are cleared asynchronously, every `row_act` bit is low, and the emitting start/cascade pin is low.
- R2: When `dir_right` is 1, the level on `start_r` is sampled at each rising clock edge into the lowest chain row (row 1). After the k-th rising edge following a single-cycle start pulse, exactly one row is active: the k-th row of the chain in ascending row order.
- R3: When `dir_right` is 0, the level on `start_l` is sampled into the highest row (row ROWS). After the k-th edge, the k-th chain row in descending order is active.
- R4: Let L be the current chain length. The emitting pin (`start_l` when shifting right, `start_r` when shifting left) goes high on the falling edge of the L-th shift clock and low on the falling edge of the (L+1)-th.
- R5: While `oe_off` is 1 and `all_on_n` is 1, all `row_act` bits are low, with no clock needed. When `oe_off` returns to 0, the pulse position held before is shown again.
- R6: While `all_on_n` is 0, rows 1 to ROWS are all high with no clock needed, whatever `oe_off` is. The exceptions are the removed rows in short mode. The stored position is kept.
- R7: When `mode_full` is 0, rows SKIP_FIRST to SKIP_FIRST+SKIP_COUNT-1 are bypassed and stay low, and the chain length is ROWS-SKIP_COUNT. When `mode_full` is 1, the chain length is ROWS.
- R8: `row_act[0]` and `row_act[ROWS+1]` are always low.
- R9: The pin at the receiving end (`start_r` when `dir_right` is 1, `start_l` otherwise) is never driven by the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; shifting on rising edge, cascade on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_right | input | 1 | 1: pulse runs from row 1 upward; 0: from row ROWS downward |
| mode_full | input | 1 | 1: full chain; 0: middle group bypassed |
| oe_off | input | 1 | 1 forces all rows inactive |
| all_on_n | input | 1 | 0 forces all rows active; overrides `oe_off` |
| start_r | inout | 1 | Start input when shifting right, cascade output when shifting left |
| start_l | inout | 1 | Start input when shifting left, cascade output when shifting right |
| row_act | output | ROWS+2 | Row-active outputs, index 0 to ROWS+1 |

## Verification
The bench builds the block with ROWS=12, SKIP_FIRST=5 and SKIP_COUNT=3, so the chains are 12 and 9 rows long. At this size a full scan in each direction and each length mode takes only a few cycles. Every row output is compared after every rising edge of each scan, and the cascade pin is checked at both half-cycles around its set and clear edges. The expected active row is computed from the position, the direction and the removed group. Override toggles in the middle of each scan show that the position is kept, including the case where the short-mode removed rows must stay dark under all-on.

// File: rtl/scan_pkg.sv
package scan_pkg;
   // True when row g lies inside the removable group
   function automatic bit in_group(int g, int first, int count);
      return (g >= first) && (g < first + count);
   endfunction
endpackage

// File: rtl/scan_chain.sv
module scan_chain #(
   parameter int ROWS       = 263,
   parameter int SKIP_FIRST = 129,
   parameter int SKIP_COUNT = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dir_right,
   input  logic            mode_full,
   input  logic            in_r,
   input  logic            in_l,
   output logic [ROWS:1]   q
);
   import scan_pkg::*;
   localparam int SKIP_LAST = SKIP_FIRST + SKIP_COUNT - 1;

   logic [ROWS:1] nxt;

   for (genvar g = 1; g <= ROWS; g++) begin : g_stage
      logic from_lo, from_hi, pick;
      if (g == 1) begin : g_lo_in
         assign from_lo = in_r;
      end else if (g == SKIP_LAST + 1) begin : g_lo_jump
         assign from_lo = mode_full ? q[g-1] : q[SKIP_FIRST-1];
      end else begin : g_lo_plain
         assign from_lo = q[g-1];
      end
      if (g == ROWS) begin : g_hi_in
         assign from_hi = in_l;
      end else if (g == SKIP_FIRST - 1) begin : g_hi_jump
         assign from_hi = mode_full ? q[g+1] : q[SKIP_LAST+1];
      end else begin : g_hi_plain
         assign from_hi = q[g+1];
      end
      assign pick = dir_right ? from_lo : from_hi;
      if (in_group(g, SKIP_FIRST, SKIP_COUNT)) begin : g_removable
         assign nxt[g] = mode_full & pick;
      end else begin : g_fixed
         assign nxt[g] = pick;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   a_r2_entry_right: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_right && in_r) |=> q[1]);
   a_r3_entry_left: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_right && in_l) |=> q[ROWS]);
   a_r7_group_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_full |=> (q[SKIP_LAST:SKIP_FIRST] == '0));
endmodule

// File: rtl/scan_cascade.sv
module scan_cascade (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_right,
   input  logic top_row,
   input  logic bottom_row,
   output logic casc
);
   logic tail;
   assign tail = dir_right ? top_row : bottom_row;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) casc <= 1'b0;
      else        casc <= tail;
   end

   a_r4_casc_follows: assert property (@(negedge clk) disable iff (!rst_n)
      (dir_right && top_row) |=> casc);
   a_r4_casc_drops: assert property (@(negedge clk) disable iff (!rst_n)
      (!top_row && !bottom_row) |=> !casc);
endmodule

// File: rtl/scan_out_gate.sv
module scan_out_gate #(
   parameter int ROWS       = 263,
   parameter int SKIP_FIRST = 129,
   parameter int SKIP_COUNT = 7
) (
   input  logic            mode_full,
   input  logic            oe_off,
   input  logic            all_on_n,
   input  logic [ROWS:1]   q,
   output logic [ROWS+1:0] row_act
);
   import scan_pkg::*;

   assign row_act[0]      = 1'b0;
   assign row_act[ROWS+1] = 1'b0;

   for (genvar g = 1; g <= ROWS; g++) begin : g_row
      logic shown;
      assign shown = !all_on_n || (!oe_off && q[g]);
      if (in_group(g, SKIP_FIRST, SKIP_COUNT)) begin : g_removable
         assign row_act[g] = mode_full && shown;
      end else begin : g_fixed
         assign row_act[g] = shown;
      end
   end
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
   parameter int ROWS       = 263,
   parameter int SKIP_FIRST = 129,
   parameter int SKIP_COUNT = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dir_right,
   input  logic            mode_full,
   input  logic            oe_off,
   input  logic            all_on_n,
   inout  wire             start_r,
   inout  wire             start_l,
   output logic [ROWS+1:0] row_act
);
   if (SKIP_COUNT < 1 || SKIP_FIRST < 2 || SKIP_FIRST + SKIP_COUNT > ROWS) begin : g_bad_cfg
      $error("row_scan_shifter: removable group must sit strictly inside the chain");
   end

   logic [ROWS:1] q;
   logic          casc;

   scan_chain #(.ROWS(ROWS), .SKIP_FIRST(SKIP_FIRST), .SKIP_COUNT(SKIP_COUNT)) u_chain (
      .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .mode_full(mode_full),
      .in_r(start_r), .in_l(start_l), .q(q));

   scan_cascade u_casc (
      .clk(clk), .rst_n(rst_n), .dir_right(dir_right),
      .top_row(q[ROWS]), .bottom_row(q[1]), .casc(casc));

   scan_out_gate #(.ROWS(ROWS), .SKIP_FIRST(SKIP_FIRST), .SKIP_COUNT(SKIP_COUNT)) u_gate (
      .mode_full(mode_full), .oe_off(oe_off), .all_on_n(all_on_n),
      .q(q), .row_act(row_act));

   // R9: only the emitting end is driven
   assign start_l = dir_right ? casc : 1'bz;
   assign start_r = dir_right ? 1'bz : casc;

   a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_off && all_on_n) |-> (row_act == '0));
   a_r6_all_on: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_on_n && mode_full) |-> (&row_act[ROWS:1]));
   a_r8_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
      !row_act[0] && !row_act[ROWS+1]);
endmodule

// File: tb/test_row_scan_shifter.sv
module test_row_scan_shifter;
   localparam int N  = 12;
   localparam int SF = 5;
   localparam int SC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_right = 1'b1, mode_full = 1'b1, oe_off = 1'b0, all_on_n = 1'b1;
   logic tb_en = 1'b0, tb_start = 1'b0;
   wire  start_r, start_l;
   logic [N+1:0] row_act;
   int   n_cmp = 0, n_bad = 0;

   assign start_r = (dir_right && tb_en)  ? tb_start : 1'bz;
   assign start_l = (!dir_right && tb_en) ? tb_start : 1'bz;

   row_scan_shifter #(.ROWS(N), .SKIP_FIRST(SF), .SKIP_COUNT(SC)) i_row_scan_shifter (
      .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .mode_full(mode_full),
      .oe_off(oe_off), .all_on_n(all_on_n), .start_r(start_r), .start_l(start_l),
      .row_act(row_act));

   always #10 clk = ~clk;

   function automatic int chain_len(bit full);
      return full ? N : N - SC;
   endfunction

   // physical row that is k-th in the chain; 0 when out of range
   function automatic int chain_row(int k, bit right, bit full);
      int p, r;
      if (k < 1 || k > chain_len(full)) return 0;
      p = right ? k : chain_len(full) + 1 - k;
      r = p;
      if (!full && r >= SF) r = r + SC;
      return r;
   endfunction

   function automatic logic [N+1:0] on_mask(bit full);
      logic [N+1:0] m = '0;
      for (int g = 1; g <= N; g++)
         if (full || g < SF || g >= SF + SC) m[g] = 1'b1;
      return m;
   endfunction

   task automatic cmp_rows(logic [N+1:0] exp, string req);
      n_cmp++;
      if (row_act !== exp) begin
         n_bad++;
         $display("FAIL %s rows act=%b exp=%b", req, row_act, exp);
      end
   endtask

   task automatic cmp_bit(logic act, logic exp, string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s pin act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic run_scan(bit right, bit full);
      int L = chain_len(full);
      logic [N+1:0] e;
      int r;
      dir_right = right; mode_full = full; oe_off = 1'b0; all_on_n = 1'b1;
      tb_en = 1'b0; tb_start = 1'b0; rst_n = 1'b0;
      #30;
      cmp_rows('0, "R1");
      cmp_bit(right ? start_l : start_r, 1'b0, "R1");
      cmp_bit(right ? start_r : start_l, 1'bz, "R9");
      @(negedge clk);
      rst_n = 1'b1; tb_en = 1'b1; tb_start = 1'b1;
      for (int k = 1; k <= L + 2; k++) begin
         @(posedge clk); #5;
         if (k == 1) tb_start = 1'b0;
         e = '0; r = chain_row(k, right, full);
         if (r > 0) e[r] = 1'b1;
         cmp_rows(e, right ? (full ? "R2" : "R7") : "R3");
         cmp_bit(right ? start_l : start_r, (k == L + 1), "R4");
         if (k == 3) begin
            oe_off = 1'b1; #1;
            cmp_rows('0, "R5");
            all_on_n = 1'b0; #1;
            cmp_rows(on_mask(full), "R6");
            all_on_n = 1'b1; #1;
            cmp_rows('0, "R5");
            oe_off = 1'b0; #1;
            cmp_rows(e, "R5");
            all_on_n = 1'b0; #1;
            cmp_rows(on_mask(full), "R6");
            all_on_n = 1'b1; #6;
         end else begin
            #10;
         end
         cmp_bit(right ? start_l : start_r, (k == L), "R4");
         cmp_bit(row_act[0] | row_act[N+1], 1'b0, "R8");
      end
   endtask

   initial begin
      #150000;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      run_scan(1'b1, 1'b1);
      run_scan(1'b0, 1'b1);
      run_scan(1'b1, 1'b0);
      run_scan(1'b0, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule